// File: doc/BRIEF.md
# Overcurrent Latch-Off Controller

This block is the digital side of an overcurrent protection scheme for a multiphase regulator. Two external comparators tell it when the load current has gone above the nominal limit and when it has gone above one and a half times that limit. A moderate overload is tolerated for a programmable delay. The shutdown latches only if the overload is still present, without a break, when that delay runs out. A severe overload latches the shutdown on the next clock edge.

Once latched, the shutdown and its recorded cause hold until the enable input is taken low. The enable input also gates all fault detection. The block also tells the analog side which limit to apply. It compares the number of active phases with the configured full phase count and outputs a scale code for the programmable total limit. It also outputs a select that swaps in a fixed per-phase limit while the voltage code is very low, as during soft-start.

Top module: `ocp_latchoff`

## Requirements
- R1: While reset is held and after it is released, `shutdown` is 0, `fault_cause` is 0 (none), `limit_scale` is 0 (full) and `per_phase_lim` is 0.
- R2: With `enable` high and no fault latched, `oc_nominal` high on TRIP_CYCLES consecutive rising edges latches a fault at the last of those edges: `shutdown` becomes 1 and `fault_cause` becomes 1 (delayed). After TRIP_CYCLES-1 such edges, `shutdown` is still 0.
- R3: One rising edge with `oc_nominal` low returns the delay timer to zero. A later trip then needs a full TRIP_CYCLES unbroken edges again.
- R4: With `enable` high and no fault latched, `oc_severe` high at a rising edge latches `shutdown`=1 with `fault_cause`=2 (immediate) at that edge. If the delayed trip expires on the same edge, the immediate cause is recorded.
- R5: While latched and `enable` stays high, `shutdown` stays 1 and `fault_cause` keeps its value whatever the comparator flags do.
- R6: A rising edge with `enable` low clears `shutdown` and `fault_cause` to 0. While `enable` is low, the flags have no effect and the delay timer is held at zero.
- R7: `limit_scale` is registered one edge after its inputs change. It is 1 (half) when `phase_total` = 2 x `phase_active`, 2 (one third) when `phase_total` = 3 x `phase_active`, and 3 (two thirds) when 2 x `phase_total` = 3 x `phase_active`. It is 0 (full) otherwise, including when `phase_active` is 0.
- R8: `per_phase_lim` equals the value of `low_vid` at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Controller enable; low clears a latched fault |
| oc_nominal | input | 1 | Comparator flag: current above 100% of limit |
| oc_severe | input | 1 | Comparator flag: current above 150% of limit |
| low_vid | input | 1 | Voltage code below the low threshold (soft-start) |
| phase_active | input | PH_W | Number of phases currently switching |
| phase_total | input | PH_W | Configured full phase count |
| shutdown | output | 1 | Latched shutdown request |
| fault_cause | output | 2 | 0 none, 1 delayed trip, 2 immediate trip |
| limit_scale | output | 2 | 0 full, 1 half, 2 one third, 3 two thirds |
| per_phase_lim | output | 1 | Selects the fixed per-phase limit |

## Verification
The hardest situation to reach is an overload that stops exactly one edge before the delay expires. A sweep over every run length from 1 to TRIP_CYCLES-1 covers it: each run is followed by a single quiet edge, and the bench checks that no fault latches. The bench then confirms that the next trip needs a full unbroken run. It also drives the severe flag on the very edge where the delay would expire. Finally, it holds both flags high while enable is low and confirms that, after enable returns, the timer starts again from zero.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE      = 2'd0,
    CAUSE_DELAYED   = 2'd1,
    CAUSE_IMMEDIATE = 2'd2
  } cause_e;

  typedef enum logic [1:0] {
    SCL_FULL       = 2'd0,
    SCL_HALF       = 2'd1,
    SCL_THIRD      = 2'd2,
    SCL_TWO_THIRDS = 2'd3
  } scale_e;

endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ocp_trip_timer.sv
module ocp_trip_timer #(
  parameter int TRIP_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int CNT_W = (TRIP_CYCLES > 2) ? $clog2(TRIP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign expire  = run && at_last;

  always_comb begin
    if (run && !at_last) cnt_d = cnt_q + 1'b1;
    else                 cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0); // R3

endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch
  import ocp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   oc_severe,
  input  logic   expire,
  output cause_e cause,
  output logic   latched
);

  cause_e cause_q, cause_d;

  always_comb begin
    if (!enable)                     cause_d = CAUSE_NONE;
    else if (cause_q != CAUSE_NONE)  cause_d = cause_q;
    else if (oc_severe)              cause_d = CAUSE_IMMEDIATE;
    else if (expire)                 cause_d = CAUSE_DELAYED;
    else                             cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_NONE;
    else        cause_q <= cause_d;
  end

  assign cause   = cause_q;
  assign latched = (cause_q != CAUSE_NONE);

  AST_IMMEDIATE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && oc_severe && !latched) |=> (latched && cause == CAUSE_IMMEDIATE)); // R4

  AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !latched && !oc_severe && !expire) |=> !latched); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && latched) |=> (latched && $stable(cause))); // R5

  AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !latched); // R6

endmodule

// File: rtl/ocp_limit_select.sv
module ocp_limit_select
  import ocp_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_active,
  input  logic [PH_W-1:0] phase_total,
  input  logic            low_vid,
  output scale_e          scale,
  output logic            per_phase
);

  localparam int MW = PH_W + 2;

  logic [MW-1:0] act_x, tot_x;
  scale_e        scale_d, scale_q;
  logic          per_phase_q;

  assign act_x = MW'(phase_active);
  assign tot_x = MW'(phase_total);

  always_comb begin
    if (act_x == '0)                      scale_d = SCL_FULL;
    else if ((act_x << 1) == tot_x)       scale_d = SCL_HALF;
    else if ((act_x * 3) == tot_x)        scale_d = SCL_THIRD;
    else if ((act_x * 3) == (tot_x << 1)) scale_d = SCL_TWO_THIRDS;
    else                                  scale_d = SCL_FULL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q     <= SCL_FULL;
      per_phase_q <= 1'b0;
    end else begin
      scale_q     <= scale_d;
      per_phase_q <= low_vid;
    end
  end

  assign scale     = scale_q;
  assign per_phase = per_phase_q;

  AST_FULL_WHEN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_active == phase_total) |=> scale == SCL_FULL); // R7

  AST_VID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    low_vid |=> per_phase); // R8

endmodule

// File: rtl/ocp_latchoff.sv
module ocp_latchoff
  import ocp_pkg::*;
#(
  parameter int TRIP_CYCLES = 12_500_000,
  parameter int PH_W        = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            oc_nominal,
  input  logic            oc_severe,
  input  logic            low_vid,
  input  logic [PH_W-1:0] phase_active,
  input  logic [PH_W-1:0] phase_total,
  output logic            shutdown,
  output logic [1:0]      fault_cause,
  output logic [1:0]      limit_scale,
  output logic            per_phase_lim
);

  logic   rst_sync_n;
  logic   timer_run;
  logic   timer_expire;
  logic   latched;
  cause_e cause;
  scale_e scale;

  ocp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign timer_run = enable && oc_nominal && !latched;

  ocp_trip_timer #(.TRIP_CYCLES(TRIP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (timer_run),
    .expire (timer_expire)
  );

  ocp_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .oc_severe (oc_severe),
    .expire    (timer_expire),
    .cause     (cause),
    .latched   (latched)
  );

  ocp_limit_select #(.PH_W(PH_W)) u_limit (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .phase_active (phase_active),
    .phase_total  (phase_total),
    .low_vid      (low_vid),
    .scale        (scale),
    .per_phase    (per_phase_lim)
  );

  assign shutdown    = latched;
  assign fault_cause = cause;
  assign limit_scale = scale;

  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(shutdown) |-> (fault_cause != 2'd0)); // R2

endmodule

// File: tb/tb_ocp_latchoff.sv
module tb_ocp_latchoff;

  localparam int TRIP = 8;
  localparam int PH_W = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            enable, oc_nominal, oc_severe, low_vid;
  logic [PH_W-1:0] phase_active, phase_total;
  logic            shutdown, per_phase_lim;
  logic [1:0]      fault_cause, limit_scale;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ocp_latchoff #(.TRIP_CYCLES(TRIP), .PH_W(PH_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .oc_nominal(oc_nominal), .oc_severe(oc_severe), .low_vid(low_vid),
    .phase_active(phase_active), .phase_total(phase_total),
    .shutdown(shutdown), .fault_cause(fault_cause),
    .limit_scale(limit_scale), .per_phase_lim(per_phase_lim)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_fault();
    enable = 1'b0; oc_nominal = 1'b0; oc_severe = 1'b0;
    step(1);
    enable = 1'b1;
    step(1);
  endtask

  function automatic int exp_scale(input int a, input int t);
    if (a == 0)           return 0;
    if (6 * a == 3 * t)   return 1;
    if (6 * a == 2 * t)   return 2;
    if (6 * a == 4 * t)   return 3;
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; oc_nominal = 1'b0; oc_severe = 1'b0;
    low_vid = 1'b0; phase_active = '0; phase_total = '0;
    step(3);
    chk("R1 shutdown in reset", shutdown, 0);
    chk("R1 cause in reset", fault_cause, 0);
    rst_n = 1'b1;
    step(4);
    chk("R1 shutdown after reset", shutdown, 0);
    chk("R1 cause after reset", fault_cause, 0);
    chk("R1 scale after reset", limit_scale, 0);
    chk("R1 per-phase after reset", per_phase_lim, 0);

    enable = 1'b1;
    // R7 / R8 exhaustive sweep
    for (int a = 0; a < 4; a++) begin
      for (int t = 0; t < 4; t++) begin
        for (int v = 0; v < 2; v++) begin
          phase_active = a[PH_W-1:0];
          phase_total  = t[PH_W-1:0];
          low_vid      = v[0];
          step(1);
          chk("R7 limit scale", limit_scale, exp_scale(a, t));
          chk("R8 per-phase select", per_phase_lim, v);
        end
      end
    end

    // R3: every run shorter than the delay, then one quiet edge
    for (int k = 1; k < TRIP; k++) begin
      oc_nominal = 1'b1;
      step(k);
      chk("R3 no trip during short run", shutdown, 0);
      oc_nominal = 1'b0;
      step(1);
      chk("R3 no trip after break", shutdown, 0);
    end

    // R2: full unbroken run
    oc_nominal = 1'b1;
    step(TRIP - 1);
    chk("R2 not yet tripped", shutdown, 0);
    step(1);
    chk("R2 delayed trip", shutdown, 1);
    chk("R2 delayed cause", fault_cause, 1);

    // R5: hold through flag activity
    for (int i = 0; i < 6; i++) begin
      oc_nominal = i[0];
      oc_severe  = i[1];
      step(1);
      chk("R5 shutdown held", shutdown, 1);
      chk("R5 cause held", fault_cause, 1);
    end

    // R6: clear with enable low, flags ignored while low
    enable = 1'b0; oc_nominal = 1'b1; oc_severe = 1'b1;
    step(1);
    chk("R6 cleared", shutdown, 0);
    chk("R6 cause cleared", fault_cause, 0);
    step(TRIP + 2);
    chk("R6 flags ignored when disabled", shutdown, 0);
    oc_severe = 1'b0;
    enable    = 1'b1;
    step(TRIP - 1);
    chk("R6 timer held at zero while disabled", shutdown, 0);
    step(1);
    chk("R6 full delay after re-enable", shutdown, 1);
    clear_fault();

    // R4: immediate trip
    oc_severe = 1'b1;
    step(1);
    chk("R4 immediate trip", shutdown, 1);
    chk("R4 immediate cause", fault_cause, 2);
    clear_fault();

    // R4: severe on the edge where the delay expires
    oc_nominal = 1'b1;
    step(TRIP - 1);
    chk("R4 pre-expiry", shutdown, 0);
    oc_severe = 1'b1;
    step(1);
    chk("R4 priority trip", shutdown, 1);
    chk("R4 priority cause", fault_cause, 2);
    clear_fault();
    step(1);
    chk("R6 final clear", shutdown, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule